// File: doc/BRIEF.md
# Cache Flush and Invalidate Sequencer

This block empties a split instruction/data cache on demand. It walks the line-state arrays one line per cycle and reads each line's tag and coherence state. It sends the address of every dirty data line to a write-back port, and it writes the Invalid state back into the array. Four operations share one walker:
- a whole flush started by a falling edge on an external active-low pin;
- a whole write-back-then-invalidate command;
- a whole invalidate-only command;
- a page-selective command that names one 4-Kbyte linear page and a write-back enable.

Only the pin-started flush finishes with a one-cycle flush-acknowledge special-cycle strobe.

The arrays are outside the block. The sequencer drives a cache select and a line index, and it receives the tag and state of that line in the same cycle. It pulses a clear strobe to write Invalid at that index. A cache-disable input combines with a record of completed whole flushes to report when the cache is truly off.

Line index layout: `{cache_select, set, way}`, where `cache_select` is 1 for the data cache. Sets are walked in ascending order, and within each set the ways are walked in ascending order. State codes are Invalid 2'b00, Shared 2'b01, Exclusive 2'b10 and Modified 2'b11. A line address is `{tag, set, zero offset}`.

Controller states:
- IDLE: leaves on a start. A pin start or a write-back command goes to WB_SCAN. An invalidate-only command goes to INV_SCAN. A page command goes to PG_SCAN.
- WB_SCAN: walks the data cache and offers each Modified line for write-back. It holds on a line until that write-back is accepted. After the last data line it goes to INV_SCAN.
- INV_SCAN: clears every line, instruction cache first and then data cache. After the last line it goes to ACK if the flush came from the pin, and to IDLE otherwise.
- PG_SCAN: walks both caches. It writes back when required and clears only the lines inside the page. After the last line it goes to IDLE.
- ACK: raises the acknowledge strobe for one cycle, then goes to IDLE.

Top module: `cache_flush_seq`

## Requirements
- R1: After reset, `busy_o`, `wb_valid_o`, `arr_clr_o`, `ack_o` and `cache_off_o` are 0 and `cmd_ready_o` is 1.
- R2: A high-to-low transition of the sampled `flush_n_i` starts a whole flush, and `busy_o` is high two clock edges after the pin falls. Holding the pin low does not start another flush.
- R3: A pin flush, or command code 0, writes back every data line in state 2'b11 in ascending `{set, way}` order, at address `{tag, set, zero offset}`. All of these write-backs are accepted before any line is cleared.
- R4: The clears of a whole flush cover every line in both caches, one per step, in ascending `{cache_select, set, way}` order with the instruction cache first. At the end every line is in state 2'b00.
- R5: Each pin-started flush produces exactly one `ack_o` pulse, one cycle long, in the cycle right after the clear of the last data line. Command flushes produce no pulse.
- R6: Command code 1 clears every line in both caches and issues no write-back.
- R7: Command code 2 clears only the lines whose address bits above bit 11 equal `cmd_page_i`, in both caches. A Modified data line in that page is written back first only when `cmd_pwb_i` is 1, and it is cleared in the cycle its write-back is accepted. Lines outside the page keep their state.
- R8: While `wb_valid_o` is high and `wb_ready_i` is low, `wb_valid_o` stays high with a stable `wb_addr_o` and the walk does not advance.
- R9: `busy_o` stays high from the start of an operation until its last step, acknowledge included. `cmd_ready_o` is low while `busy_o` is high or a pin start is waiting. A pin start beats a command that is offered in the same cycle, and that command is served afterwards.
- R10: Command code 3 is accepted and has no effect: no busy, no write-back, no clear.
- R11: `cache_off_o` is 1 only while `cd_i` is 1 and a whole flush (pin, code 0 or code 1) has finished since `cd_i` last became 1. Setting `cd_i` alone, or running a page flush, leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_n_i | input | 1 | External active-low flush request, sampled |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command taken this cycle when valid |
| cmd_op_i | input | 2 | 0 write back and invalidate, 1 invalidate only, 2 page, 3 no operation |
| cmd_page_i | input | ADDR_W-12 | Linear page number for code 2 |
| cmd_pwb_i | input | 1 | Page flush writes back dirty lines |
| arr_dc_o | output | 1 | Array select, 1 = data cache |
| arr_idx_o | output | SET_W+WAY_W | `{set, way}` of the addressed line |
| arr_tag_i | input | TAG_W | Tag of the addressed line |
| arr_state_i | input | 2 | State of the addressed line |
| arr_clr_o | output | 1 | Write Invalid to the addressed line |
| wb_valid_o | output | 1 | Write-back request |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_addr_o | output | ADDR_W | Line address to write back |
| ack_o | output | 1 | Flush-acknowledge special-cycle strobe |
| busy_o | output | 1 | Operation in progress |
| cd_i | input | 1 | Cache-disable bit |
| cache_off_o | output | 1 | Cache fully disabled |

## Verification
The pin edge detector and the command handshake can fire in the same cycle. The bench lowers `flush_n_i` and then raises `cmd_valid_i` with code 0 half a cycle after the pin is sampled. It requires `cmd_ready_o` to be low in that cycle and exactly one acknowledge pulse to follow. The queued command must still run after the pin flush, and it must find nothing left to write back. The bench also sweeps all operations over several preloaded mixes of line states, with and without write-back stalls. It compares write-back order, clear order and final states against values it computes from the preload formulas.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_E = 2'b10,
        LS_M = 2'b11
    } lstate_t;

    typedef enum logic [1:0] {
        OP_WBINV = 2'd0,
        OP_INV   = 2'd1,
        OP_PAGE  = 2'd2,
        OP_NONE  = 2'd3
    } cmd_op_t;

    typedef enum logic [1:0] {
        K_PIN   = 2'd0,
        K_WBINV = 2'd1,
        K_INV   = 2'd2,
        K_PAGE  = 2'd3
    } kind_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WB_SCAN  = 3'd1,
        ST_INV_SCAN = 3'd2,
        ST_PG_SCAN  = 3'd3,
        ST_ACK      = 3'd4
    } seq_st_t;

endpackage

// File: rtl/cfs_req_arb.sv
module cfs_req_arb
    import cfs_pkg::*;
#(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_n_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [PAGE_W-1:0] cmd_page_i,
    input  logic              cmd_pwb_i,
    input  logic              idle_i,
    output logic              cmd_ready_o,
    output logic              start_o,
    output kind_t             start_kind_o,
    output logic [PAGE_W-1:0] start_page_o,
    output logic              start_pwb_o
);

    logic pin_s1_q;
    logic pin_s2_q;
    logic pend_q;
    logic fall_w;
    logic pin_go_w;
    logic cmd_fire_w;

    // two-stage sample of the pin; a start is taken on its falling edge only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_s1_q <= 1'b1;
            pin_s2_q <= 1'b1;
        end else begin
            pin_s1_q <= flush_n_i;
            pin_s2_q <= pin_s1_q;
        end
    end

    assign fall_w   = pin_s2_q & ~pin_s1_q;
    assign pin_go_w = idle_i & (pend_q | fall_w);

    // an edge seen while busy is held until the walker is free again
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (pin_go_w) begin
            pend_q <= 1'b0;
        end else if (fall_w) begin
            pend_q <= 1'b1;
        end
    end

    assign cmd_ready_o = idle_i & ~pend_q & ~fall_w;
    assign cmd_fire_w  = cmd_valid_i & cmd_ready_o;

    always_comb begin
        start_o      = 1'b0;
        start_kind_o = K_PIN;
        start_page_o = cmd_page_i;
        start_pwb_o  = cmd_pwb_i;
        if (pin_go_w) begin
            start_o      = 1'b1;
            start_kind_o = K_PIN;
        end else if (cmd_fire_w) begin
            unique case (cmd_op_t'(cmd_op_i))
                OP_WBINV: begin start_o = 1'b1; start_kind_o = K_WBINV; end
                OP_INV:   begin start_o = 1'b1; start_kind_o = K_INV;   end
                OP_PAGE:  begin start_o = 1'b1; start_kind_o = K_PAGE;  end
                OP_NONE:  begin start_o = 1'b0; start_kind_o = K_PIN;   end
            endcase
        end
    end

    AST_PIN_BEATS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_w || pend_q) |-> !cmd_ready_o); // R9

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && idle_i) |=> !pend_q || !idle_i); // R9

endmodule

// File: rtl/cfs_walk_ctr.sv
module cfs_walk_ctr #(
    parameter int LIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_zero_i,
    input  logic              ld_dhalf_i,
    input  logic              inc_i,
    output logic [LIDX_W-1:0] idx_o,
    output logic              last_o
);

    localparam logic [LIDX_W-1:0] DHALF = {1'b1, {(LIDX_W-1){1'b0}}};

    logic [LIDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (ld_zero_i) begin
            idx_q <= '0;
        end else if (ld_dhalf_i) begin
            idx_q <= DHALF;
        end else if (inc_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = &idx_q;

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_zero_i, ld_dhalf_i, inc_i}) <= 1); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_zero_i && !ld_dhalf_i) |-> !last_o); // R4

endmodule

// File: rtl/cfs_seq_fsm.sv
module cfs_seq_fsm
    import cfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SET_W  = 3,
    parameter int WAY_W  = 1,
    parameter int TAG_W  = 24,
    parameter int PAGE_W = 20,
    parameter int LIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  kind_t             kind_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              pwb_i,
    input  logic [LIDX_W-1:0] idx_i,
    input  logic              last_i,
    input  logic [TAG_W-1:0]  arr_tag_i,
    input  logic [1:0]        arr_state_i,
    input  logic              wb_ready_i,
    output logic              idle_o,
    output logic              ctr_ld_zero_o,
    output logic              ctr_ld_dhalf_o,
    output logic              ctr_inc_o,
    output logic              arr_clr_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic              ack_o,
    output logic              whole_done_o
);

    seq_st_t           st_q;
    seq_st_t           st_d;
    kind_t             kind_q;
    logic [PAGE_W-1:0] page_q;
    logic              pwb_q;

    logic              dc_w;
    logic [SET_W-1:0]  set_w;
    logic [ADDR_W-1:0] line_addr_w;
    logic              pg_hit_w;
    logic              mod_dc_w;
    logic              need_wb_w;
    logic              adv_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // operation parameters held for the whole walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_PIN;
            page_q <= '0;
            pwb_q  <= 1'b0;
        end else if (start_i && (st_q == ST_IDLE)) begin
            kind_q <= kind_i;
            page_q <= page_i;
            pwb_q  <= pwb_i;
        end
    end

    // per-line decode
    assign dc_w        = idx_i[LIDX_W-1];
    assign set_w       = idx_i[WAY_W +: SET_W];
    assign line_addr_w = {arr_tag_i, set_w, {OFF_W{1'b0}}};
    assign pg_hit_w    = (line_addr_w[ADDR_W-1:12] == page_q);
    assign mod_dc_w    = dc_w && (arr_state_i == LS_M);

    always_comb begin
        unique case (st_q)
            ST_WB_SCAN: need_wb_w = mod_dc_w;
            ST_PG_SCAN: need_wb_w = pg_hit_w && mod_dc_w && pwb_q;
            default:    need_wb_w = 1'b0;
        endcase
    end

    assign adv_w     = !need_wb_w || wb_ready_i;
    assign wb_addr_o = line_addr_w;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    unique case (kind_i)
                        K_PIN, K_WBINV: st_d = ST_WB_SCAN;
                        K_INV:          st_d = ST_INV_SCAN;
                        K_PAGE:         st_d = ST_PG_SCAN;
                    endcase
                end
            end
            ST_WB_SCAN: begin
                if (adv_w && last_i) st_d = ST_INV_SCAN;
            end
            ST_INV_SCAN: begin
                if (last_i) st_d = (kind_q == K_PIN) ? ST_ACK : ST_IDLE;
            end
            ST_PG_SCAN: begin
                if (adv_w && last_i) st_d = ST_IDLE;
            end
            ST_ACK: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        ctr_ld_zero_o  = 1'b0;
        ctr_ld_dhalf_o = 1'b0;
        ctr_inc_o      = 1'b0;
        arr_clr_o      = 1'b0;
        wb_valid_o     = 1'b0;
        ack_o          = 1'b0;
        whole_done_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (kind_i == K_PIN || kind_i == K_WBINV) begin
                        ctr_ld_dhalf_o = 1'b1;
                    end else begin
                        ctr_ld_zero_o = 1'b1;
                    end
                end
            end
            ST_WB_SCAN: begin
                wb_valid_o = need_wb_w;
                if (adv_w) begin
                    if (last_i) ctr_ld_zero_o = 1'b1;
                    else        ctr_inc_o     = 1'b1;
                end
            end
            ST_INV_SCAN: begin
                arr_clr_o = 1'b1;
                if (last_i) whole_done_o = 1'b1;
                else        ctr_inc_o    = 1'b1;
            end
            ST_PG_SCAN: begin
                wb_valid_o = need_wb_w;
                if (adv_w) begin
                    arr_clr_o = pg_hit_w && (arr_state_i != LS_I);
                    if (!last_i) ctr_inc_o = 1'b1;
                end
            end
            ST_ACK: begin
                ack_o = 1'b1;
            end
            default: begin
                ack_o = 1'b0;
            end
        endcase
    end

    assign idle_o = (st_q == ST_IDLE);

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o))); // R8

    AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (arr_state_i == LS_M && idx_i[LIDX_W-1])); // R3

    AST_CLR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_clr_o && wb_valid_o) |-> wb_ready_i); // R7

    AST_INVONLY_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && kind_q == K_INV) |-> !wb_valid_o); // R6

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R5

endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
    import cfs_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int OFF_W  = 5,
    parameter  int SETS   = 8,
    parameter  int WAYS   = 2,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int PAGE_W = ADDR_W - 12,
    localparam int LIDX_W = 1 + SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_n_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_op_i,
    input  logic [PAGE_W-1:0] cmd_page_i,
    input  logic              cmd_pwb_i,
    output logic              arr_dc_o,
    output logic [LIDX_W-2:0] arr_idx_o,
    input  logic [TAG_W-1:0]  arr_tag_i,
    input  logic [1:0]        arr_state_i,
    output logic              arr_clr_o,
    output logic              wb_valid_o,
    input  logic              wb_ready_i,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic              ack_o,
    output logic              busy_o,
    input  logic              cd_i,
    output logic              cache_off_o
);

    logic              idle_w;
    logic              start_w;
    kind_t             kind_w;
    logic [PAGE_W-1:0] page_w;
    logic              pwb_w;
    logic              ld_zero_w;
    logic              ld_dhalf_w;
    logic              inc_w;
    logic [LIDX_W-1:0] idx_w;
    logic              last_w;
    logic              whole_done_w;
    logic              clean_q;

    cfs_req_arb #(
        .PAGE_W (PAGE_W)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_n_i    (flush_n_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (cmd_op_i),
        .cmd_page_i   (cmd_page_i),
        .cmd_pwb_i    (cmd_pwb_i),
        .idle_i       (idle_w),
        .cmd_ready_o  (cmd_ready_o),
        .start_o      (start_w),
        .start_kind_o (kind_w),
        .start_page_o (page_w),
        .start_pwb_o  (pwb_w)
    );

    cfs_walk_ctr #(
        .LIDX_W (LIDX_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_zero_i  (ld_zero_w),
        .ld_dhalf_i (ld_dhalf_w),
        .inc_i      (inc_w),
        .idx_o      (idx_w),
        .last_o     (last_w)
    );

    cfs_seq_fsm #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .SET_W  (SET_W),
        .WAY_W  (WAY_W),
        .TAG_W  (TAG_W),
        .PAGE_W (PAGE_W),
        .LIDX_W (LIDX_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_w),
        .kind_i         (kind_w),
        .page_i         (page_w),
        .pwb_i          (pwb_w),
        .idx_i          (idx_w),
        .last_i         (last_w),
        .arr_tag_i      (arr_tag_i),
        .arr_state_i    (arr_state_i),
        .wb_ready_i     (wb_ready_i),
        .idle_o         (idle_w),
        .ctr_ld_zero_o  (ld_zero_w),
        .ctr_ld_dhalf_o (ld_dhalf_w),
        .ctr_inc_o      (inc_w),
        .arr_clr_o      (arr_clr_o),
        .wb_valid_o     (wb_valid_o),
        .wb_addr_o      (wb_addr_o),
        .ack_o          (ack_o),
        .whole_done_o   (whole_done_w)
    );

    assign arr_dc_o  = idx_w[LIDX_W-1];
    assign arr_idx_o = idx_w[LIDX_W-2:0];
    assign busy_o    = ~idle_w;

    // a finished whole flush counts only while the disable bit stays set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_q <= 1'b0;
        end else if (!cd_i) begin
            clean_q <= 1'b0;
        end else if (whole_done_w) begin
            clean_q <= 1'b1;
        end
    end

    assign cache_off_o = cd_i & clean_q;

    AST_OFF_NEEDS_CD: assert property (@(posedge clk) disable iff (!rst_n)
        cache_off_o |-> cd_i); // R11

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cmd_ready_o); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!arr_clr_o && !wb_valid_o && !ack_o)); // R10

endmodule

// File: tb/cache_flush_seq_tb_top.sv
`timescale 1ns/1ps
module cache_flush_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 5;
    localparam int SETS   = 8;
    localparam int WAYS   = 2;
    localparam int NL     = SETS * WAYS;
    localparam int TAG_W  = ADDR_W - OFF_W - 3;
    localparam int PAGE_W = ADDR_W - 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              flush_n;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [1:0]        cmd_op;
    logic [PAGE_W-1:0] cmd_page;
    logic              cmd_pwb;
    logic              arr_dc;
    logic [3:0]        arr_idx;
    logic [TAG_W-1:0]  arr_tag;
    logic [1:0]        arr_state;
    logic              arr_clr;
    logic              wb_valid;
    logic              wb_ready;
    logic [ADDR_W-1:0] wb_addr;
    logic              ack;
    logic              busy;
    logic              cd;
    logic              cache_off;

    always #2.5 clk = ~clk;

    cache_flush_seq #(
        .ADDR_W (ADDR_W), .OFF_W (OFF_W), .SETS (SETS), .WAYS (WAYS)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .flush_n_i (flush_n),
        .cmd_valid_i (cmd_valid), .cmd_ready_o (cmd_ready), .cmd_op_i (cmd_op),
        .cmd_page_i (cmd_page), .cmd_pwb_i (cmd_pwb),
        .arr_dc_o (arr_dc), .arr_idx_o (arr_idx), .arr_tag_i (arr_tag),
        .arr_state_i (arr_state), .arr_clr_o (arr_clr),
        .wb_valid_o (wb_valid), .wb_ready_i (wb_ready), .wb_addr_o (wb_addr),
        .ack_o (ack), .busy_o (busy), .cd_i (cd), .cache_off_o (cache_off)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // preload formulas
    function automatic logic [19:0] f_pg(input int s);
        return 20'(32'h12345 + s);
    endfunction
    function automatic logic [19:0] f_hi(input int s, input int i);
        return (((i + s) % 3) == 0) ? (f_pg(s) ^ 20'h00F00) : f_pg(s);
    endfunction
    function automatic logic [1:0] f_dst(input int s, input int i);
        return 2'((i * 5 + s * 3 + (i >> 2)) % 4);
    endfunction
    function automatic logic [1:0] f_ist(input int s, input int i);
        return 2'((i * 3 + s) % 3);
    endfunction
    function automatic logic [TAG_W-1:0] f_dtag(input int s, input int i);
        return {f_hi(s, i), 4'(i * 3 + s)};
    endfunction
    function automatic logic [TAG_W-1:0] f_itag(input int s, input int i);
        return {f_hi(s, i + 1), 4'(i * 5 + s)};
    endfunction

    // cache model and monitors
    logic [TAG_W-1:0] ic_tag [NL];
    logic [TAG_W-1:0] dc_tag [NL];
    logic [1:0]       ic_st  [NL];
    logic [1:0]       dc_st  [NL];
    logic [ADDR_W-1:0] exp_wb [NL];
    int  exp_n = 0;
    bit  do_load = 1'b0;
    int  ld_seed = 0;
    bit  chk_seq = 1'b0;
    bit  chk_early = 1'b0;
    bit  stall = 1'b0;

    int wb_cnt, ord_err, early_err, clr_ord_err, ack_cnt, ack_err, stall_err, rb_err, clr_cnt;
    logic [4:0] clr_seq;
    logic prev_last_clr, prev_hold;
    logic [ADDR_W-1:0] prev_addr;

    always_comb begin
        arr_tag   = arr_dc ? dc_tag[arr_idx] : ic_tag[arr_idx];
        arr_state = arr_dc ? dc_st[arr_idx] : ic_st[arr_idx];
    end

    always @(posedge clk) begin
        if (do_load) begin
            for (int i = 0; i < NL; i++) begin
                dc_st[i]  <= f_dst(ld_seed, i);
                ic_st[i]  <= f_ist(ld_seed, i);
                dc_tag[i] <= f_dtag(ld_seed, i);
                ic_tag[i] <= f_itag(ld_seed, i);
            end
            wb_cnt <= 0; ord_err <= 0; early_err <= 0; clr_ord_err <= 0;
            ack_cnt <= 0; ack_err <= 0; stall_err <= 0; rb_err <= 0; clr_cnt <= 0;
            clr_seq <= '0; prev_last_clr <= 1'b0; prev_hold <= 1'b0; prev_addr <= '0;
        end else begin
            if (arr_clr) begin
                if (arr_dc) dc_st[arr_idx] <= 2'b00;
                else        ic_st[arr_idx] <= 2'b00;
                clr_cnt <= clr_cnt + 1;
                if (chk_seq && ({arr_dc, arr_idx} != clr_seq)) clr_ord_err <= clr_ord_err + 1;
                clr_seq <= clr_seq + 1'b1;
                if (chk_early && (wb_cnt < exp_n)) early_err <= early_err + 1;
            end
            if (wb_valid && wb_ready) begin
                if (wb_cnt >= exp_n || wb_addr != exp_wb[wb_cnt]) ord_err <= ord_err + 1;
                wb_cnt <= wb_cnt + 1;
            end
            if (ack) begin
                ack_cnt <= ack_cnt + 1;
                if (!prev_last_clr) ack_err <= ack_err + 1;
            end
            if (prev_hold && (!wb_valid || wb_addr != prev_addr)) stall_err <= stall_err + 1;
            if (busy && cmd_ready) rb_err <= rb_err + 1;
            prev_last_clr <= arr_clr && arr_dc && (&arr_idx);
            prev_hold     <= wb_valid && !wb_ready;
            prev_addr     <= wb_addr;
        end
    end

    int cyc = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        wb_ready <= stall ? ((cyc % 3) == 2) : 1'b1;
    end

    // stimulus tasks
    task automatic load(input int s);
        @(negedge clk);
        ld_seed = s;
        do_load = 1'b1;
        @(negedge clk);
        do_load = 1'b0;
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [PAGE_W-1:0] pg, input bit pwb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; cmd_pwb = pwb;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // kind: 0 pin, 1 write back + invalidate, 2 invalidate only, 3 page
    task automatic run(input int kind, input int s, input bit pwb);
        int mis;
        int rep;
        exp_n = 0;
        for (int i = 0; i < NL; i++) begin
            if (f_dst(s, i) == 2'b11 &&
                (kind <= 1 || (kind == 3 && pwb && f_hi(s, i) == f_pg(s)))) begin
                exp_wb[exp_n] = {f_dtag(s, i), 3'(i >> 1), 5'b0};
                exp_n++;
            end
        end
        chk_seq   = (kind <= 2);
        chk_early = (kind <= 1);
        stall     = s[0];
        load(s);
        if (kind == 0) begin
            @(negedge clk);
            flush_n = 1'b0;
            repeat (2) @(negedge clk);
            check(busy == 1'b1, "R2 busy after pin fall", busy, 1);
            while (busy) @(negedge clk);
            rep = 0;
            repeat (20) begin
                @(negedge clk);
                if (busy) rep++;
            end
            check(rep == 0, "R2 held pin restarted", rep, 0);
            flush_n = 1'b1;
            @(negedge clk);
        end else begin
            send_cmd((kind == 1) ? 2'd0 : (kind == 2) ? 2'd1 : 2'd2, f_pg(s), pwb);
            check(busy == 1'b1 || kind == 3, "R9 busy after accept", busy, 1);
            wait_done();
        end
        check(wb_cnt == exp_n, (kind == 2) ? "R6 write-back count" :
              (kind == 3) ? "R7 write-back count" : "R3 write-back count", wb_cnt, exp_n);
        check(ord_err == 0, "R3 write-back order/address", ord_err, 0);
        check(early_err == 0, "R3 clear before write-backs done", early_err, 0);
        check(clr_ord_err == 0, "R4 clear order", clr_ord_err, 0);
        check(stall_err == 0, "R8 stall stability", stall_err, 0);
        check(rb_err == 0, "R9 ready while busy", rb_err, 0);
        check(ack_cnt == ((kind == 0) ? 1 : 0), "R5 ack count", ack_cnt, (kind == 0) ? 1 : 0);
        check(ack_err == 0, "R5 ack timing", ack_err, 0);
        mis = 0;
        for (int i = 0; i < NL; i++) begin
            logic [1:0] ed, ei;
            ed = (kind <= 2 || (kind == 3 && f_hi(s, i) == f_pg(s)))     ? 2'b00 : f_dst(s, i);
            ei = (kind <= 2 || (kind == 3 && f_hi(s, i + 1) == f_pg(s))) ? 2'b00 : f_ist(s, i);
            if (dc_st[i] != ed) mis++;
            if (ic_st[i] != ei) mis++;
        end
        check(mis == 0, (kind == 3) ? "R7 final line states" : "R4 final line states", mis, 0);
    endtask

    initial begin
        int mis;
        rst_n = 1'b0; flush_n = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0;
        cmd_page = '0; cmd_pwb = 1'b0; cd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && wb_valid == 0 && arr_clr == 0 && ack == 0, "R1 reset outputs quiet",
              {busy, wb_valid, arr_clr, ack}, 0);
        check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
        check(cache_off == 1'b0, "R1 cache_off after reset", cache_off, 0);

        // sweep: every operation over several preloads, stalls on odd seeds
        for (int s = 0; s < 4; s++) begin
            run(0, s, 1'b0);
            run(1, s, 1'b0);
            run(2, s, 1'b0);
            run(3, s, 1'b1);
            run(3, s, 1'b0);
        end

        // R10 no-operation code
        load(2);
        send_cmd(2'd3, '0, 1'b0);
        mis = 0;
        repeat (5) begin
            @(negedge clk);
            if (busy) mis++;
        end
        check(mis == 0, "R10 no-op raised busy", mis, 0);
        check(wb_cnt == 0 && clr_cnt == 0, "R10 no-op touched lines", wb_cnt + clr_cnt, 0);

        // R9 pin and command in the same cycle
        exp_n = 0;
        for (int i = 0; i < NL; i++)
            if (f_dst(1, i) == 2'b11) begin
                exp_wb[exp_n] = {f_dtag(1, i), 3'(i >> 1), 5'b0};
                exp_n++;
            end
        chk_seq = 1'b0; chk_early = 1'b0; stall = 1'b0;
        load(1);
        @(negedge clk);
        flush_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_page = '0; cmd_pwb = 1'b0;
        #0.5;
        check(cmd_ready == 1'b0, "R9 pin beats command", cmd_ready, 0);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        flush_n = 1'b1;
        wait_done();
        check(ack_cnt == 1, "R9 single ack for pin start", ack_cnt, 1);
        check(wb_cnt == exp_n && ord_err == 0, "R9 queued command found nothing dirty", wb_cnt, exp_n);
        check(clr_cnt == 4 * NL, "R9 both flushes cleared all lines", clr_cnt, 4 * NL);

        // R11 disable tracking
        load(0);
        @(negedge clk);
        cd = 1'b1;
        repeat (2) @(negedge clk);
        check(cache_off == 1'b0, "R11 bit alone", cache_off, 0);
        send_cmd(2'd1, '0, 1'b0);
        wait_done();
        check(cache_off == 1'b1, "R11 after whole flush", cache_off, 1);
        cd = 1'b0;
        #0.5;
        check(cache_off == 1'b0, "R11 bit cleared", cache_off, 0);
        @(negedge clk);
        cd = 1'b1;
        @(negedge clk);
        check(cache_off == 1'b0, "R11 bit set again", cache_off, 0);
        send_cmd(2'd2, f_pg(0), 1'b1);
        wait_done();
        check(cache_off == 1'b0, "R11 page flush does not count", cache_off, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule